// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block keeps one status code per hardware thread for the instruction fetch stage of a multithreaded core. It updates every code once per clock. Its inputs are:

- hold and release pulses from four downstream stages;
- squash requests from a late and an early stage;
- a flag saying the reorder buffer is still squashing;
- instruction cache responses and retry grants;
- per-turn events reported by the fetch datapath: a request sent, a request refused, a fault, or a quiesce.

The block also keeps the single retry slot that all threads share, and a counter of cache responses that were thrown away. Its stage-active output tells the core whether fetch has any work left to do.

Each thread has one latch per downstream stage, which records that stage's hold. The per-thread update follows a fixed priority, so that a squash, a stall and a cache event arriving in the same cycle always resolve the same way. The datapath learns through the status codes which threads may fetch, and it drives one fetch turn per cycle.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After reset every thread reads RUNNING. No stage hold is latched, the retry slot is free (`cache_blocked`=0) and `discard_cnt`=0. Status codes are 4 bits wide, and thread t reads `status_o[4t+3:4t]`. The codes are 0 IDLE, 1 RUNNING, 2 SQUASHING, 3 BLOCKED, 4 WAIT_RESP, 5 WAIT_RETRY, 6 ACC_DONE, 7 TRAP_PEND and 8 QUIESCE_PEND.
- R2: Each thread latches one hold bit per stage (decode, rename, execute, commit). A hold pulse sets the bit. A release pulse clears it. A hold wins over a release in the same cycle. A release of a bit that is already clear has no effect. A thread counts as stalled when any of its bits (updated this cycle) is set or `ctx_switch` is high.
- R3: Each cycle the first matching rule applies, in this order:
  1. A late squash sets SQUASHING.
  2. The reorder-buffer flag sets SQUASHING.
  3. An early squash sets SQUASHING, unless the thread is already SQUASHING.
  4. Stall handling.
  5. The resume rule.
  6. Cache and turn events.
- R4: A stalled thread moves to BLOCKED from any status except WAIT_RESP and WAIT_RETRY, which hold their status.
- R5: A thread in BLOCKED or SQUASHING returns to RUNNING on the first cycle with no squash and no stall.
- R6: A response is accepted only if the thread is in WAIT_RESP, no squash reaches it that cycle, and `resp_tag` equals the tag of its outstanding request. Any other response is discarded, and each discard increments `discard_cnt`.
- R7: An accepted response moves the thread to BLOCKED if it is stalled, and to ACC_DONE otherwise.
- R8: On a fetch turn (`turn_op`: 0 plain, 1 sent, 2 refused, 3 fault, 4 quiesce):
  - A thread in ACC_DONE moves to RUNNING, whatever the op.
  - A thread in RUNNING moves to WAIT_RESP on op 1, recording `turn_tag`.
  - A thread in RUNNING moves to WAIT_RETRY on op 2 and claims the retry slot, but only if the slot is free. If the slot is taken, the thread stays RUNNING.
  - A thread in RUNNING moves to TRAP_PEND on op 3 and to QUIESCE_PEND on op 4.
- R9: `retry_grant` moves the slot owner from WAIT_RETRY to WAIT_RESP and frees the slot. The recorded tag becomes the outstanding tag.
- R10: A squash of a thread in WAIT_RESP abandons its request, so a later response with that tag is discarded. A squash of the slot owner frees the slot and clears `cache_blocked`.
- R11: `stage_active` is high when any active thread is in RUNNING, SQUASHING or ACC_DONE.
- R12: A thread whose `thread_active` bit is low keeps its status, whatever the squash, stall, cache or turn inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_active | input | NUM_THREADS | Threads taking part in fetch |
| dec_hold | input | NUM_THREADS | Decode hold pulse per thread |
| dec_release | input | NUM_THREADS | Decode release pulse per thread |
| ren_hold | input | NUM_THREADS | Rename hold pulse per thread |
| ren_release | input | NUM_THREADS | Rename release pulse per thread |
| exe_hold | input | NUM_THREADS | Execute hold pulse per thread |
| exe_release | input | NUM_THREADS | Execute release pulse per thread |
| cmt_hold | input | NUM_THREADS | Commit hold pulse per thread |
| cmt_release | input | NUM_THREADS | Commit release pulse per thread |
| ctx_switch | input | 1 | Global stall during a context switch |
| late_squash | input | NUM_THREADS | Squash request from the late stage |
| rob_squash | input | NUM_THREADS | Reorder buffer still squashing |
| early_squash | input | NUM_THREADS | Squash request from the early stage |
| turn_valid | input | 1 | A fetch turn event is present |
| turn_tid | input | TID_W | Thread of the fetch turn |
| turn_op | input | 3 | Turn event code |
| turn_tag | input | TAG_W | Tag of the request sent or refused |
| resp_valid | input | 1 | Cache response present |
| resp_tid | input | TID_W | Thread of the response |
| resp_tag | input | TAG_W | Tag of the response |
| retry_grant | input | 1 | Cache accepts the request held in the retry slot |
| status_o | output | 4*NUM_THREADS | Status code per thread |
| stage_active | output | 1 | Fetch has work this cycle |
| cache_blocked | output | 1 | Retry slot is occupied |
| discard_cnt | output | CNT_W | Count of discarded responses |

## Verification
The bench builds the block with NUM_THREADS=3, TAG_W=4 and CNT_W=8. A thread count that is not a power of two leaves an unused thread-index code. Three threads let one thread hold the retry slot while a second is refused and a third keeps fetching. Four-bit tags make it possible to send a response with a stale tag and a response with the correct tag to the same waiting thread, so both the discard path and the accept path are exercised.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    localparam int STAT_W = 4;
    localparam int NUM_STAGES = 4;

    typedef enum logic [STAT_W-1:0] {
        ST_IDLE       = 4'd0,
        ST_RUN        = 4'd1,
        ST_SQUASH     = 4'd2,
        ST_BLOCK      = 4'd3,
        ST_WAIT_RESP  = 4'd4,
        ST_WAIT_RETRY = 4'd5,
        ST_ACC_DONE   = 4'd6,
        ST_TRAP       = 4'd7,
        ST_QUIESCE    = 4'd8
    } fstat_e;

    typedef enum logic [2:0] {
        OP_TURN    = 3'd0,
        OP_SENT    = 3'd1,
        OP_REFUSED = 3'd2,
        OP_FAULT   = 3'd3,
        OP_QUIESCE = 3'd4
    } turn_op_e;
endpackage

// File: rtl/fsc_stall_track.sv
module fsc_stall_track #(
    parameter int NUM_STAGES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STAGES-1:0] hold_i,
    input  logic [NUM_STAGES-1:0] release_i,
    input  logic                  ctx_switch,
    output logic                  stalled_o
);
    logic [NUM_STAGES-1:0] stall_d, stall_q;

    // hold wins over release in the same cycle
    always_comb begin
        stall_d = (stall_q & ~release_i) | hold_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stall_q <= '0;
        else        stall_q <= stall_d;
    end

    assign stalled_o = (|stall_d) | ctx_switch;

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_chk
        // R2
        hold_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hold_i[s] |=> stall_q[s]);
    end
endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
    import fsc_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              stalled,
    input  logic              late_sq,
    input  logic              rob_sq,
    input  logic              early_sq,
    input  logic              resp_hit,
    input  logic [TAG_W-1:0]  resp_tag,
    input  logic              turn_hit,
    input  logic [2:0]        turn_op,
    input  logic [TAG_W-1:0]  turn_tag,
    input  logic              grant_hit,
    input  logic              slot_free,
    input  logic              slot_mine,
    output logic [STAT_W-1:0] status_o,
    output logic              claim_o,
    output logic              release_o,
    output logic              accept_o
);
    typedef struct packed {
        fstat_e             status;
        logic [TAG_W-1:0]   tag;
    } thr_st_t;

    thr_st_t st_d, st_q;
    logic    squash_now;

    always_comb begin
        st_d       = st_q;
        claim_o    = 1'b0;
        release_o  = 1'b0;
        accept_o   = 1'b0;
        squash_now = 1'b0;
        if (active) begin
            if (late_sq || rob_sq || (early_sq && st_q.status != ST_SQUASH)) begin
                st_d.status = ST_SQUASH;
                squash_now  = 1'b1;
            end else if (stalled && st_q.status != ST_WAIT_RESP &&
                         st_q.status != ST_WAIT_RETRY) begin
                st_d.status = ST_BLOCK;
            end else if (st_q.status == ST_BLOCK || st_q.status == ST_SQUASH) begin
                st_d.status = ST_RUN;
            end else begin
                case (st_q.status)
                    ST_WAIT_RESP: begin
                        if (resp_hit && resp_tag == st_q.tag) begin
                            accept_o    = 1'b1;
                            st_d.status = stalled ? ST_BLOCK : ST_ACC_DONE;
                        end
                    end
                    ST_WAIT_RETRY: begin
                        if (grant_hit) begin
                            st_d.status = ST_WAIT_RESP;
                            release_o   = 1'b1;
                        end
                    end
                    ST_ACC_DONE: begin
                        if (turn_hit) st_d.status = ST_RUN;
                    end
                    ST_RUN: begin
                        if (turn_hit) begin
                            case (turn_op_e'(turn_op))
                                OP_SENT: begin
                                    st_d.status = ST_WAIT_RESP;
                                    st_d.tag    = turn_tag;
                                end
                                OP_REFUSED: begin
                                    if (slot_free) begin
                                        st_d.status = ST_WAIT_RETRY;
                                        st_d.tag    = turn_tag;
                                        claim_o     = 1'b1;
                                    end
                                end
                                OP_FAULT:   st_d.status = ST_TRAP;
                                OP_QUIESCE: st_d.status = ST_QUIESCE;
                                default:    ;
                            endcase
                        end
                    end
                    default: ;
                endcase
            end
            if (squash_now && slot_mine) release_o = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.status <= ST_RUN;
            st_q.tag    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;

    // R3
    late_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && late_sq) |=> status_o == ST_SQUASH);

    // R4
    retry_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && status_o == ST_WAIT_RETRY && !late_sq && !rob_sq &&
         !early_sq && !grant_hit) |=> status_o == ST_WAIT_RETRY);

    // R5
    resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && status_o == ST_BLOCK && !stalled && !late_sq && !rob_sq &&
         !early_sq) |=> status_o == ST_RUN);
endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
    import fsc_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int TAG_W       = 4,
    parameter int CNT_W       = 8,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_THREADS-1:0]        thread_active,
    input  logic [NUM_THREADS-1:0]        dec_hold,
    input  logic [NUM_THREADS-1:0]        dec_release,
    input  logic [NUM_THREADS-1:0]        ren_hold,
    input  logic [NUM_THREADS-1:0]        ren_release,
    input  logic [NUM_THREADS-1:0]        exe_hold,
    input  logic [NUM_THREADS-1:0]        exe_release,
    input  logic [NUM_THREADS-1:0]        cmt_hold,
    input  logic [NUM_THREADS-1:0]        cmt_release,
    input  logic                          ctx_switch,
    input  logic [NUM_THREADS-1:0]        late_squash,
    input  logic [NUM_THREADS-1:0]        rob_squash,
    input  logic [NUM_THREADS-1:0]        early_squash,
    input  logic                          turn_valid,
    input  logic [TID_W-1:0]              turn_tid,
    input  logic [2:0]                    turn_op,
    input  logic [TAG_W-1:0]              turn_tag,
    input  logic                          resp_valid,
    input  logic [TID_W-1:0]              resp_tid,
    input  logic [TAG_W-1:0]              resp_tag,
    input  logic                          retry_grant,
    output logic [STAT_W*NUM_THREADS-1:0] status_o,
    output logic                          stage_active,
    output logic                          cache_blocked,
    output logic [CNT_W-1:0]              discard_cnt
);
    typedef struct packed {
        logic             owner_valid;
        logic [TID_W-1:0] owner;
        logic [CNT_W-1:0] cnt;
    } top_st_t;

    top_st_t top_d, top_q;

    logic [STAT_W-1:0]      stat [NUM_THREADS];
    logic [NUM_THREADS-1:0] stalled, claim, release_v, accept;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        fsc_stall_track #(.NUM_STAGES(NUM_STAGES)) u_stall (
            .clk       (clk),
            .rst_n     (rst_n),
            .hold_i    ({cmt_hold[t], exe_hold[t], ren_hold[t], dec_hold[t]}),
            .release_i ({cmt_release[t], exe_release[t], ren_release[t], dec_release[t]}),
            .ctx_switch(ctx_switch),
            .stalled_o (stalled[t])
        );

        fsc_thread_fsm #(.TAG_W(TAG_W)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .active    (thread_active[t]),
            .stalled   (stalled[t]),
            .late_sq   (late_squash[t]),
            .rob_sq    (rob_squash[t]),
            .early_sq  (early_squash[t]),
            .resp_hit  (resp_valid && resp_tid == TID_W'(t)),
            .resp_tag  (resp_tag),
            .turn_hit  (turn_valid && turn_tid == TID_W'(t)),
            .turn_op   (turn_op),
            .turn_tag  (turn_tag),
            .grant_hit (retry_grant && top_q.owner_valid && top_q.owner == TID_W'(t)),
            .slot_free (!top_q.owner_valid),
            .slot_mine (top_q.owner_valid && top_q.owner == TID_W'(t)),
            .status_o  (stat[t]),
            .claim_o   (claim[t]),
            .release_o (release_v[t]),
            .accept_o  (accept[t])
        );

        assign status_o[t*STAT_W +: STAT_W] = stat[t];
    end

    always_comb begin
        top_d = top_q;
        if (|release_v) top_d.owner_valid = 1'b0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (claim[t]) begin
                top_d.owner_valid = 1'b1;
                top_d.owner       = TID_W'(t);
            end
        end
        if (resp_valid && !(|accept)) top_d.cnt = top_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    always_comb begin
        stage_active = 1'b0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (thread_active[t] && (stat[t] == ST_RUN || stat[t] == ST_SQUASH ||
                                     stat[t] == ST_ACC_DONE))
                stage_active = 1'b1;
        end
    end

    assign cache_blocked = top_q.owner_valid;
    assign discard_cnt   = top_q.cnt;

    // R9
    slot_owner_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_q.owner_valid |-> stat[top_q.owner] == ST_WAIT_RETRY);

    // R6
    discard_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !(|accept)) |=> discard_cnt == CNT_W'($past(discard_cnt) + 1'b1));
endmodule

// File: tb/tb_fetch_status_ctrl.sv
module tb_fetch_status_ctrl;
    localparam int N  = 3;
    localparam int TW = 4;
    localparam int CW = 8;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] thread_active, dec_hold, dec_release, ren_hold, ren_release;
    logic [N-1:0] exe_hold, exe_release, cmt_hold, cmt_release;
    logic [N-1:0] late_squash, rob_squash, early_squash;
    logic ctx_switch, turn_valid, resp_valid, retry_grant;
    logic [IW-1:0] turn_tid, resp_tid;
    logic [2:0] turn_op;
    logic [TW-1:0] turn_tag, resp_tag;
    logic [4*N-1:0] status_o;
    logic stage_active, cache_blocked;
    logic [CW-1:0] discard_cnt;

    int total = 0;
    int bad = 0;
    int exp_cnt = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fetch_status_ctrl #(.NUM_THREADS(N), .TAG_W(TW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .thread_active(thread_active),
        .dec_hold(dec_hold), .dec_release(dec_release),
        .ren_hold(ren_hold), .ren_release(ren_release),
        .exe_hold(exe_hold), .exe_release(exe_release),
        .cmt_hold(cmt_hold), .cmt_release(cmt_release),
        .ctx_switch(ctx_switch), .late_squash(late_squash),
        .rob_squash(rob_squash), .early_squash(early_squash),
        .turn_valid(turn_valid), .turn_tid(turn_tid), .turn_op(turn_op),
        .turn_tag(turn_tag), .resp_valid(resp_valid), .resp_tid(resp_tid),
        .resp_tag(resp_tag), .retry_grant(retry_grant), .status_o(status_o),
        .stage_active(stage_active), .cache_blocked(cache_blocked),
        .discard_cnt(discard_cnt)
    );

    task automatic clear_pulses();
        dec_hold = '0; dec_release = '0; ren_hold = '0; ren_release = '0;
        exe_hold = '0; exe_release = '0; cmt_hold = '0; cmt_release = '0;
        late_squash = '0; rob_squash = '0; early_squash = '0; ctx_switch = 0;
        turn_valid = 0; turn_tid = '0; turn_op = '0; turn_tag = '0;
        resp_valid = 0; resp_tid = '0; resp_tag = '0; retry_grant = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        clear_pulses();
    endtask

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int st(int t);
        return int'((status_o >> (4 * t)) & 12'hF);
    endfunction

    task automatic turn(int t, int op, int tag);
        turn_valid = 1; turn_tid = IW'(t); turn_op = 3'(op); turn_tag = TW'(tag);
    endtask

    task automatic respond(int t, int tag);
        resp_valid = 1; resp_tid = IW'(t); resp_tag = TW'(tag);
    endtask

    task automatic t_reset();
        for (int t = 0; t < N; t++) check("R1 status", st(t), 1);
        check("R1 cache_blocked", cache_blocked, 0);
        check("R1 discard_cnt", discard_cnt, 0);
        check("R11 active after reset", stage_active, 1);
    endtask

    task automatic t_stall();
        dec_hold[0] = 1; tick();
        check("R4 hold blocks", st(0), 3);
        ren_release[0] = 1; tick();
        check("R2 release of clear bit no effect", st(0), 3);
        dec_release[0] = 1; tick();
        check("R5 resume", st(0), 1);
        exe_release[1] = 1; tick();
        check("R2 release clear bit thread1", st(1), 1);
        exe_hold[1] = 1; exe_release[1] = 1; tick();
        check("R2 hold wins", st(1), 3);
        exe_release[1] = 1; tick();
        check("R5 resume thread1", st(1), 1);
        ctx_switch = 1; tick();
        for (int t = 0; t < N; t++) check("R2 ctx_switch stalls", st(t), 3);
        tick();
        for (int t = 0; t < N; t++) check("R5 resume after ctx", st(t), 1);
    endtask

    task automatic t_priority();
        late_squash[0] = 1; early_squash[0] = 1; dec_hold[0] = 1; tick();
        check("R3 late squash over stall", st(0), 2);
        rob_squash[0] = 1; tick();
        check("R3 rob holds squashing", st(0), 2);
        early_squash[0] = 1; tick();
        check("R3 early ignored when squashing", st(0), 3);
        dec_release[0] = 1; tick();
        check("R5 resume after block", st(0), 1);
        early_squash[2] = 1; cmt_hold[2] = 1; tick();
        check("R3 early squash over stall", st(2), 2);
        cmt_release[2] = 1; tick();
        check("R5 resume thread2", st(2), 1);
    endtask

    task automatic t_cache();
        turn(1, 1, 5); tick();
        check("R8 sent", st(1), 4);
        cmt_hold[1] = 1; tick();
        check("R4 wait_resp exempt", st(1), 4);
        respond(1, 6); tick(); exp_cnt++;
        check("R6 wrong tag kept waiting", st(1), 4);
        check("R6 wrong tag counted", discard_cnt, exp_cnt);
        respond(1, 5); tick();
        check("R7 accepted while stalled", st(1), 3);
        check("R6 accepted not counted", discard_cnt, exp_cnt);
        cmt_release[1] = 1; tick();
        check("R5 resume thread1", st(1), 1);
        turn(1, 1, 2); tick();
        respond(1, 2); tick();
        check("R7 accepted to acc_done", st(1), 6);
        turn(1, 0, 0); tick();
        check("R8 acc_done to running", st(1), 1);
    endtask

    task automatic t_retry();
        turn(2, 2, 7); tick();
        check("R8 refused claims slot", st(2), 5);
        check("R8 cache_blocked set", cache_blocked, 1);
        turn(0, 2, 1); tick();
        check("R8 refused slot busy", st(0), 1);
        dec_hold[2] = 1; tick();
        check("R4 wait_retry exempt", st(2), 5);
        retry_grant = 1; tick();
        check("R9 grant to wait_resp", st(2), 4);
        check("R9 slot freed", cache_blocked, 0);
        respond(2, 7); tick();
        check("R9 retried tag accepted stalled", st(2), 3);
        dec_release[2] = 1; tick();
        check("R5 resume thread2", st(2), 1);
    endtask

    task automatic t_abandon();
        turn(0, 1, 3); tick();
        late_squash[0] = 1; tick();
        check("R10 squash wait_resp", st(0), 2);
        respond(0, 3); tick(); exp_cnt++;
        check("R10 abandoned response discarded", discard_cnt, exp_cnt);
        check("R10 thread resumes", st(0), 1);
        turn(1, 2, 1); tick();
        check("R8 thread1 takes slot", cache_blocked, 1);
        late_squash[1] = 1; tick();
        check("R10 squash owner", st(1), 2);
        check("R10 squash frees slot", cache_blocked, 0);
        tick();
        check("R5 thread1 resumes", st(1), 1);
    endtask

    task automatic t_fault();
        turn(2, 3, 0); tick();
        check("R8 fault", st(2), 7);
        turn(1, 4, 0); tick();
        check("R8 quiesce", st(1), 8);
        check("R11 thread0 running keeps active", stage_active, 1);
        thread_active = 3'b110; tick();
        check("R11 no runnable active thread", stage_active, 0);
        dec_hold[0] = 1; late_squash[0] = 1; tick();
        check("R12 inactive thread holds", st(0), 1);
        dec_release[0] = 1; tick();
        late_squash[1] = 1; late_squash[2] = 1; tick();
        check("R3 squash from quiesce", st(1), 2);
        check("R3 squash from trap", st(2), 2);
        check("R11 squashing counts active", stage_active, 1);
        thread_active = 3'b111; tick();
        for (int t = 0; t < N; t++) check("R5 all running", st(t), 1);
    endtask

    initial begin
        thread_active = 3'b111;
        clear_pulses();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_stall();
        t_priority();
        t_cache();
        t_retry();
        t_abandon();
        t_fault();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule